// File: doc/BRIEF.md
# Dual Byte FIFO with Threshold Interrupts

This block sits between a serial shift engine and the host register port of a serial peripheral controller. It holds a transmit queue that software fills and the engine drains, and a receive queue that the engine fills and software drains. Each queue holds 64 bytes. Each has a programmable threshold, an occupancy count visible to software, and a reset request bit that clears itself.

Software sees six word registers on a simple read/write port. A status register collects the queue conditions and the engine's completion and select-release pulses. Its bits are cleared by writing ones. An enable register masks the status bits onto a single interrupt line. Software typically sets the thresholds, fills the transmit queue and enables the request interrupts. It then serves each interrupt by topping up the transmit queue or emptying the receive queue, until the completion bit arrives.

Top module: `fifo_pair_regs`

## Requirements
- R1: After reset both counts are zero, the control register (address 2) and the enable register (address 0) read zero, and `irq` is low.
- R2: Each write to address 4 appends `reg_wdata[7:0]` to the transmit queue. Each `eng_tx_pop` removes the oldest byte, which is shown on `eng_tx_data` during the pop cycle. The transmit count reads at bits 23:16 of address 3.
- R3: Each `eng_rx_push` appends `eng_rx_data` to the receive queue. A read of address 5 returns the oldest byte in bits 7:0 and removes it. The receive count reads at bits 7:0 of address 3. A read of an empty receive queue returns zero.
- R4: A push into a full queue (64 bytes) is dropped. It sets the sticky overrun status bit: bit 10 for transmit, bit 8 for receive.
- R5: A pop from an empty queue is dropped and returns zero. It sets the sticky underrun status bit: bit 9 for a receive read, bit 11 for an engine pop.
- R6: Status bit 4 (transmit request) is set while the transmit count ≤ the transmit threshold (control bits 23:16). Status bit 0 (receive ready) is set while the receive count ≥ the receive threshold (control bits 7:0).
- R7: Status bits 1 and 5 are set while the receive and transmit queues, respectively, are empty. Bits 2 and 6 are set while they are full.
- R8: Writing address 1 clears each status bit written as 1 and leaves the bits written as 0. A bit whose condition is still present is set again in the same cycle.
- R9: Writing control bit 31 (transmit) or bit 15 (receive) empties that queue on the following cycle. The bit reads back as 1 for exactly one cycle and as 0 afterwards, so a control word written with zero thresholds then reads zero.
- R10: A pulse on `eng_done` sets status bit 12, and a pulse on `eng_cs_release` sets status bit 13. Both bits hold until cleared.
- R11: The enable register keeps only the implemented bits (mask 0x3F77). `irq` is the OR of status AND enable, registered one cycle after the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at address 5) |
| reg_addr | input | 3 | Word address: 0 enable, 1 status, 2 control, 3 counts, 4 transmit data, 5 receive data |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the same cycle as `reg_rd`, zero otherwise |
| eng_tx_pop | input | 1 | Engine takes one transmit byte |
| eng_tx_data | output | 8 | Oldest transmit byte, zero when empty |
| eng_rx_push | input | 1 | Engine delivers one receive byte |
| eng_rx_data | input | 8 | Receive byte from the engine |
| eng_done | input | 1 | Transfer-complete pulse |
| eng_cs_release | input | 1 | Select-release pulse |
| irq | output | 1 | Interrupt request |

## Verification
A wrong pointer or count in either queue shows up at the ports within one access. The byte returned by the next pop differs from the byte pushed, or the count field at address 3 reads wrong on the next read. A mismatch between the threshold compare and the count shows in the status word on the first read after a write-one clear. A lost sticky flag or a wrong enable mask shows on `irq` two cycles after the event that should have raised it.

// File: rtl/fifo_pair_pkg.sv
package fifo_pair_pkg;

    localparam int DATA_W = 8;
    localparam int TRIG_W = 8;
    localparam int STAT_W = 14;

    typedef enum logic [2:0] {
        SEL_IEN   = 3'd0,
        SEL_STAT  = 3'd1,
        SEL_CTRL  = 3'd2,
        SEL_LEVEL = 3'd3,
        SEL_TXD   = 3'd4,
        SEL_RXD   = 3'd5
    } reg_sel_e;

    localparam int S_RX_READY = 0;
    localparam int S_RX_EMPTY = 1;
    localparam int S_RX_FULL  = 2;
    localparam int S_TX_REQ   = 4;
    localparam int S_TX_EMPTY = 5;
    localparam int S_TX_FULL  = 6;
    localparam int S_RX_OVF   = 8;
    localparam int S_RX_UDF   = 9;
    localparam int S_TX_OVF   = 10;
    localparam int S_TX_UDF   = 11;
    localparam int S_DONE     = 12;
    localparam int S_CS_REL   = 13;

    localparam logic [STAT_W-1:0] STAT_IMPL = 14'h3F77;

    typedef struct packed {
        logic              tx_rst;
        logic [TRIG_W-1:0] tx_trig;
        logic              rx_rst;
        logic [TRIG_W-1:0] rx_trig;
    } fifo_ctrl_t;

    typedef struct packed {
        logic full;
        logic empty;
        logic ovf;
        logic udf;
    } fifo_evt_t;

    function automatic logic [31:0] ctrl_word(fifo_ctrl_t c);
        return {c.tx_rst, 7'b0, c.tx_trig, c.rx_rst, 7'b0, c.rx_trig};
    endfunction

    function automatic logic [31:0] level_word(logic [TRIG_W-1:0] rxc,
                                               logic [TRIG_W-1:0] txc);
        return {8'b0, txc, 8'b0, rxc};
    endfunction

endpackage

// File: rtl/byte_fifo.sv
module byte_fifo
    import fifo_pair_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CW-1:0]    count,
    output fifo_evt_t        evt
);
    localparam bit POW2 = (DEPTH & (DEPTH - 1)) == 0;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr, wr_next, rd_next;
    logic             is_full, is_empty, do_push, do_pop;

    assign is_full  = (count == CW'(DEPTH));
    assign is_empty = (count == '0);
    assign do_push  = push && !is_full;
    assign do_pop   = pop && !is_empty;

    generate
        if (POW2) begin : g_wrap_free
            assign wr_next = wr_ptr + 1'b1;
            assign rd_next = rd_ptr + 1'b1;
        end else begin : g_wrap_cmp
            assign wr_next = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            assign rd_next = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_next;
            if (do_pop)  rd_ptr <= rd_next;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wr_ptr] <= push_data;
    end

    assign head      = is_empty ? '0 : mem[rd_ptr];
    assign evt.full  = is_full;
    assign evt.empty = is_empty;
    assign evt.ovf   = push && is_full;
    assign evt.udf   = pop && is_empty;
endmodule

// File: rtl/irq_status.sv
module irq_status
    import fifo_pair_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [STAT_W-1:0] cond,
    input  logic [STAT_W-1:0] clr_mask,
    input  logic              en_we,
    input  logic [STAT_W-1:0] en_wdata,
    output logic [STAT_W-1:0] status,
    output logic [STAT_W-1:0] enable,
    output logic              irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            enable <= '0;
            irq    <= 1'b0;
        end else begin
            status <= (status & ~clr_mask) | cond;
            if (en_we) enable <= en_wdata & STAT_IMPL;
            irq <= |(status & enable);
        end
    end
endmodule

// File: rtl/fifo_pair_regs.sv
module fifo_pair_regs
    import fifo_pair_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              eng_tx_pop,
    output logic [DATA_W-1:0] eng_tx_data,
    input  logic              eng_rx_push,
    input  logic [DATA_W-1:0] eng_rx_data,
    input  logic              eng_done,
    input  logic              eng_cs_release,
    output logic              irq
);
    fifo_ctrl_t        ctrl_q;
    logic              tx_pend, rx_pend;
    logic [CW-1:0]     tx_count, rx_count;
    logic [TRIG_W-1:0] tx_cnt8, rx_cnt8;
    logic [DATA_W-1:0] rx_head;
    fifo_evt_t         tx_evt, rx_evt;
    logic [STAT_W-1:0] cond, clr_mask, status, enable;
    logic              wr_ctrl, wr_txd, rd_rxd;
    logic              tx_full, rx_empty;
    logic              unused_wbits;

    assign wr_ctrl  = reg_wr && (reg_addr == SEL_CTRL);
    assign wr_txd   = reg_wr && (reg_addr == SEL_TXD);
    assign rd_rxd   = reg_rd && (reg_addr == SEL_RXD);
    assign tx_pend  = ctrl_q.tx_rst;
    assign rx_pend  = ctrl_q.rx_rst;
    assign unused_wbits = ^{reg_wdata[30:24], reg_wdata[14]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q.tx_rst <= 1'b0;
            ctrl_q.rx_rst <= 1'b0;
            if (wr_ctrl) begin
                ctrl_q.tx_trig <= reg_wdata[23:16];
                ctrl_q.rx_trig <= reg_wdata[7:0];
                ctrl_q.tx_rst  <= reg_wdata[31];
                ctrl_q.rx_rst  <= reg_wdata[15];
            end
        end
    end

    byte_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst(rst), .clr(tx_pend),
        .push(wr_txd), .push_data(reg_wdata[DATA_W-1:0]),
        .pop(eng_tx_pop), .head(eng_tx_data),
        .count(tx_count), .evt(tx_evt)
    );

    byte_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .clr(rx_pend),
        .push(eng_rx_push), .push_data(eng_rx_data),
        .pop(rd_rxd), .head(rx_head),
        .count(rx_count), .evt(rx_evt)
    );

    assign tx_cnt8  = TRIG_W'(tx_count);
    assign rx_cnt8  = TRIG_W'(rx_count);
    assign tx_full  = tx_evt.full;
    assign rx_empty = rx_evt.empty;

    always_comb begin
        cond             = '0;
        cond[S_RX_READY] = rx_cnt8 >= ctrl_q.rx_trig;
        cond[S_RX_EMPTY] = rx_evt.empty;
        cond[S_RX_FULL]  = rx_evt.full;
        cond[S_TX_REQ]   = tx_cnt8 <= ctrl_q.tx_trig;
        cond[S_TX_EMPTY] = tx_evt.empty;
        cond[S_TX_FULL]  = tx_evt.full;
        cond[S_RX_OVF]   = rx_evt.ovf;
        cond[S_RX_UDF]   = rx_evt.udf;
        cond[S_TX_OVF]   = tx_evt.ovf;
        cond[S_TX_UDF]   = tx_evt.udf;
        cond[S_DONE]     = eng_done;
        cond[S_CS_REL]   = eng_cs_release;
    end

    assign clr_mask = (reg_wr && (reg_addr == SEL_STAT)) ? reg_wdata[STAT_W-1:0] : '0;

    irq_status u_irq (
        .clk(clk), .rst(rst), .cond(cond), .clr_mask(clr_mask),
        .en_we(reg_wr && (reg_addr == SEL_IEN)),
        .en_wdata(reg_wdata[STAT_W-1:0]),
        .status(status), .enable(enable), .irq(irq)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            case (reg_addr)
                SEL_IEN:   reg_rdata = {{(32-STAT_W){1'b0}}, enable};
                SEL_STAT:  reg_rdata = {{(32-STAT_W){1'b0}}, status};
                SEL_CTRL:  reg_rdata = ctrl_word(ctrl_q);
                SEL_LEVEL: reg_rdata = level_word(rx_cnt8, tx_cnt8);
                SEL_RXD:   reg_rdata = {{(32-DATA_W){1'b0}}, rx_head};
                default:   reg_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/fifo_pair_checker.sv
module fifo_pair_checker
    import fifo_pair_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CW = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [2:0]        reg_addr,
    input logic [31:0]       reg_wdata,
    input logic [31:0]       reg_rdata,
    input logic              eng_tx_pop,
    input logic              eng_done,
    input logic [STAT_W-1:0] status,
    input logic [STAT_W-1:0] enable,
    input logic              irq,
    input logic [CW-1:0]     tx_count,
    input logic              tx_full,
    input logic              rx_empty,
    input logic              tx_pend
);
    assert_irq_low_R11: assert property (@(posedge clk) disable iff (rst)
        ((status & enable) == '0) |=> !irq);

    assert_irq_high_R11: assert property (@(posedge clk) disable iff (rst)
        ((status & enable) != '0) |=> irq);

    assert_tx_bound_R2: assert property (@(posedge clk) disable iff (rst)
        tx_count <= CW'(DEPTH));

    assert_tx_drop_R4: assert property (@(posedge clk) disable iff (rst)
        (tx_full && reg_wr && reg_addr == 3'd4 && !eng_tx_pop && !tx_pend)
        |=> tx_count == CW'(DEPTH));

    assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        (status[S_TX_OVF] && !(reg_wr && reg_addr == 3'd1 && reg_wdata[S_TX_OVF]))
        |=> status[S_TX_OVF]);

    assert_empty_read_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == 3'd5 && rx_empty) |-> reg_rdata == 32'd0);

    assert_reset_clears_R9: assert property (@(posedge clk) disable iff (rst)
        tx_pend |=> tx_count == '0);

    assert_done_latch_R10: assert property (@(posedge clk) disable iff (rst)
        eng_done |=> status[S_DONE]);
endmodule

bind fifo_pair_regs fifo_pair_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_tx_pop(eng_tx_pop), .eng_done(eng_done),
    .status(status), .enable(enable), .irq(irq),
    .tx_count(tx_count), .tx_full(tx_full), .rx_empty(rx_empty),
    .tx_pend(tx_pend)
);

// File: tb/sim_fifo_pair_regs.sv
module sim_fifo_pair_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 0, reg_rd = 0;
    logic [2:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        eng_tx_pop = 0, eng_rx_push = 0, eng_done = 0, eng_cs_release = 0;
    logic [7:0]  eng_tx_data, eng_rx_data = 0;
    logic        irq;

    int total = 0, fails = 0;
    bit finished = 0;
    logic [7:0] txq[$];
    logic [7:0] rxq[$];

    always #4 clk = ~clk;

    fifo_pair_regs u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
        .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
        .eng_done(eng_done), .eng_cs_release(eng_cs_release), .irq(irq)
    );

    function automatic logic [31:0] exp_level(int rxn, int txn);
        return {8'b0, 8'(txn), 8'b0, 8'(rxn)};
    endfunction

    function automatic logic [31:0] exp_ctrl(bit txr, int txt, bit rxr, int rxt);
        return {txr, 7'b0, 8'(txt), rxr, 7'b0, 8'(rxt)};
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr_reg(logic [2:0] a, logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd_reg(logic [2:0] a, output logic [31:0] d);
        reg_rd = 1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic eng_push(logic [7:0] b);
        eng_rx_push = 1; eng_rx_data = b;
        @(negedge clk);
        eng_rx_push = 0;
    endtask

    task automatic eng_pop(output logic [7:0] b);
        eng_tx_pop = 1;
        #1 b = eng_tx_data;
        @(negedge clk);
        eng_tx_pop = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            total++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [7:0]  b;
        int errs;
        void'($urandom(32'd20461));
        repeat (4) @(negedge clk);
        rst = 0;
        idle(2);

        // R1 reset state
        rd_reg(3'd3, d); chk("R1 level", d, 32'd0);
        rd_reg(3'd2, d); chk("R1 ctrl", d, 32'd0);
        rd_reg(3'd0, d); chk("R1 enable", d, 32'd0);
        chk("R1 irq", 32'(irq), 32'd0);
        // R6/R7 empty queues with zero thresholds
        rd_reg(3'd1, d); chk("R6 R7 idle status", d, 32'h33);

        // R11 enable mask
        wr_reg(3'd0, 32'hFFFF_FFFF);
        rd_reg(3'd0, d); chk("R11 enable mask", d, 32'h3F77);
        wr_reg(3'd0, 32'h0);

        // R2 transmit order, random bytes
        for (int i = 0; i < 20; i++) begin
            b = 8'($urandom); txq.push_back(b); wr_reg(3'd4, {24'b0, b});
        end
        rd_reg(3'd3, d); chk("R2 tx count", d, exp_level(0, 20));
        errs = 0;
        for (int i = 0; i < 20; i++) begin
            eng_pop(b); if (b !== txq.pop_front()) errs++;
        end
        chk("R2 tx order", 32'(errs), 32'd0);

        // R3 receive order
        for (int i = 0; i < 10; i++) begin
            b = 8'($urandom); rxq.push_back(b); eng_push(b);
        end
        rd_reg(3'd3, d); chk("R3 rx count", d, exp_level(10, 0));
        errs = 0;
        for (int i = 0; i < 10; i++) begin
            rd_reg(3'd5, d); if (d !== {24'b0, rxq.pop_front()}) errs++;
        end
        chk("R3 rx order", 32'(errs), 32'd0);

        // R5 underruns
        rd_reg(3'd5, d); chk("R3 R5 empty read data", d, 32'd0);
        eng_pop(b); chk("R5 empty pop data", 32'(b), 32'd0);
        rd_reg(3'd1, d);
        chk("R5 rx underrun bit9", 32'(d[9]), 32'd1);
        chk("R5 tx underrun bit11", 32'(d[11]), 32'd1);
        rd_reg(3'd3, d); chk("R5 counts stay zero", d, 32'd0);

        // R4 transmit overrun
        for (int i = 0; i < 64; i++) wr_reg(3'd4, 32'(i));
        wr_reg(3'd4, 32'hEE);
        rd_reg(3'd3, d); chk("R4 tx count capped", d, exp_level(0, 64));
        rd_reg(3'd1, d);
        chk("R4 tx overrun bit10", 32'(d[10]), 32'd1);
        chk("R7 tx full bit6", 32'(d[6]), 32'd1);
        errs = 0;
        for (int i = 0; i < 64; i++) begin
            eng_pop(b); if (b !== 8'(i)) errs++;
        end
        chk("R4 tx extra byte dropped", 32'(errs), 32'd0);

        // R4 receive overrun, R8 write-one clear
        for (int i = 0; i < 64; i++) eng_push(8'(i + 100));
        eng_push(8'hEE);
        rd_reg(3'd3, d); chk("R4 rx count capped", d, exp_level(64, 0));
        rd_reg(3'd1, d);
        chk("R4 rx overrun bit8", 32'(d[8]), 32'd1);
        chk("R7 rx full bit2", 32'(d[2]), 32'd1);
        wr_reg(3'd1, 32'h0);
        rd_reg(3'd1, d); chk("R8 zero write keeps bit8", 32'(d[8]), 32'd1);
        wr_reg(3'd1, 32'h0104);
        rd_reg(3'd1, d);
        chk("R8 bit8 cleared", 32'(d[8]), 32'd0);
        chk("R8 bit2 reasserts", 32'(d[2]), 32'd1);
        errs = 0;
        for (int i = 0; i < 64; i++) begin
            rd_reg(3'd5, d); if (d !== 32'(i + 100)) errs++;
        end
        chk("R4 rx extra byte dropped", 32'(errs), 32'd0);
        wr_reg(3'd1, 32'h3FFF);
        rd_reg(3'd1, d); chk("R8 clear all leaves live bits", d, 32'h33);

        // R6 thresholds
        wr_reg(3'd2, exp_ctrl(0, 3, 0, 2));
        for (int i = 0; i < 4; i++) wr_reg(3'd4, 32'(i));
        wr_reg(3'd1, 32'h3FFF);
        rd_reg(3'd1, d); chk("R6 tx req off at 4>3", 32'(d[4]), 32'd0);
        eng_pop(b);
        wr_reg(3'd1, 32'h3FFF);
        rd_reg(3'd1, d); chk("R6 tx req on at 3", 32'(d[4]), 32'd1);
        eng_push(8'h11);
        wr_reg(3'd1, 32'h3FFF);
        rd_reg(3'd1, d); chk("R6 rx ready off at 1<2", 32'(d[0]), 32'd0);
        eng_push(8'h22);
        wr_reg(3'd1, 32'h3FFF);
        rd_reg(3'd1, d); chk("R6 rx ready on at 2", 32'(d[0]), 32'd1);

        // R9 self-clearing queue reset
        wr_reg(3'd2, exp_ctrl(1, 0, 1, 0));
        rd_reg(3'd2, d); chk("R9 reset bits visible one cycle", d, exp_ctrl(1, 0, 1, 0));
        rd_reg(3'd2, d); chk("R9 ctrl reads zero", d, 32'd0);
        rd_reg(3'd3, d); chk("R9 queues emptied", d, 32'd0);

        // R10 / R11 engine pulses and interrupt timing
        wr_reg(3'd1, 32'h3FFF);
        wr_reg(3'd0, 32'h1000);
        eng_done = 1; @(negedge clk); eng_done = 0;
        chk("R11 irq waits one cycle", 32'(irq), 32'd0);
        idle(1);
        chk("R10 R11 irq on done", 32'(irq), 32'd1);
        rd_reg(3'd1, d); chk("R10 done bit12", 32'(d[12]), 32'd1);
        wr_reg(3'd1, 32'h1000);
        idle(1);
        chk("R11 irq drops after clear", 32'(irq), 32'd0);
        eng_cs_release = 1; @(negedge clk); eng_cs_release = 0;
        idle(2);
        rd_reg(3'd1, d); chk("R10 cs release bit13", 32'(d[13]), 32'd1);
        chk("R11 masked bit13 no irq", 32'(irq), 32'd0);
        wr_reg(3'd0, 32'h0);

        // R2 R3 mixed random traffic against queue model
        errs = 0;
        for (int i = 0; i < 600; i++) begin
            case ($urandom % 4)
                0: begin
                    b = 8'($urandom);
                    if (txq.size() < 64) txq.push_back(b);
                    wr_reg(3'd4, {24'b0, b});
                end
                1: begin
                    eng_pop(b);
                    if (txq.size() > 0) begin
                        if (b !== txq.pop_front()) errs++;
                    end else if (b !== 8'd0) errs++;
                end
                2: begin
                    b = 8'($urandom);
                    if (rxq.size() < 64) rxq.push_back(b);
                    eng_push(b);
                end
                default: begin
                    rd_reg(3'd5, d);
                    if (rxq.size() > 0) begin
                        if (d !== {24'b0, rxq.pop_front()}) errs++;
                    end else if (d !== 32'd0) errs++;
                end
            endcase
        end
        chk("R2 R3 random data", 32'(errs), 32'd0);
        rd_reg(3'd3, d); chk("R2 R3 random counts", d, exp_level(rxq.size(), txq.size()));

        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule